// File: doc/BRIEF.md
# Heartbeat-Locked Animation Frame Sequencer

This block selects which image of a sixteen-image looping animation a video pipeline shows. It advances the animation once per display refresh, and it keeps that motion phase-locked to the heartbeat. Each time a heartbeat peak is detected, one complete sixteen-image loop is scheduled. A feedback loop then tunes a fractional per-refresh increment so that the loop takes about as long as one beat.

The block counts refresh strobes between peaks to measure the beat period, and it keeps a running average of that period. The animation position is a fixed-point number with eight fractional bits. It never passes a goal position, and the goal moves forward by sixteen frames on every peak. When a peak arrives, the block predicts where the position would land one averaged period later at the current increment. It then corrects the increment by the prediction error scaled down by 256. Image storage and pixel generation sit outside the block; its output is the 4-bit index of the image to show.

Top module: `beat_anim_sequencer`

## Requirements
- R1: After reset, the frame index is 0, the averaged period is 60 refreshes, the goal is 0 and the step is floor(16·256/60) = 68 (Q.8). The index therefore stays at 0 on refreshes until the first peak.
- R2: The position is a 16-bit unsigned value with 8 fractional bits. The frame index output is position bits [11:8], which is the integer frame number modulo 16.
- R3: On a cycle with a refresh strobe, the position grows by the step, but by no more than the distance left to the goal. On a cycle without a refresh strobe, the position holds. The position never passes the goal.
- R4: The measured period counts the refresh strobes since the last peak or reset. A strobe in the same cycle as the peak is included. The count saturates at 1023, and a peak clears it.
- R5: On a peak, the averaged period becomes floor((averaged period + measured period)/2).
- R6: On a peak, the goal advances by 16 frames (4096 in Q.8), unless that would put it more than 64 frames ahead of the position. In that case it stays where it is.
- R7: On a peak, the step becomes step − floor((position + new period × step − new goal)/256). Here position and step are the values before that clock edge.
- R8: After each update, the step is clamped to the range 0 to 1024 (0 to 4.0 frames per refresh).
- R9: With peaks arriving every 40 refreshes, the loop settles so that the animation reaches its goal, index 0, by the end of each beat.
- R10: The step, the averaged period and the goal change only on a cycle with a peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_i | input | 1 | One-cycle strobe per video refresh |
| peak_i | input | 1 | One-cycle strobe per detected heartbeat peak |
| frame_idx_o | output | 4 | Image index to display, 0 to 15 |

## Verification
Several properties are checked on every cycle. The position never runs past the goal, and it never falls more than 64 frames behind it. The step stays within its clamp. The step, period and goal move only on a peak. A peak clears the refresh count. What the bench's scenarios must show is the arithmetic itself, observed through the frame index. This covers the averaging and prediction-correction of the step, the counting of a strobe that coincides with a peak, saturation of a very long beat, the lead cap under a burst of peaks, and settling into one loop per beat.

// File: rtl/beat_anim_pkg.sv
package beat_anim_pkg;
    // Default geometry of the sequencer
    localparam int FRAC_BITS_DEF   = 8;   // fractional bits of position and step
    localparam int LOOP_LEN_DEF    = 16;  // images in one animation loop
    localparam int POS_BITS_DEF    = 16;  // position / goal register width
    localparam int PERIOD_BITS_DEF = 10;  // refresh count and averaged period width
    localparam int STEP_CAP_DEF    = 4;   // maximum step in whole frames per refresh
    localparam int LEAD_LOOPS_DEF  = 4;   // maximum goal lead, in loops
    localparam int PERIOD_INIT_DEF = 60;  // averaged period after reset
endpackage

// File: rtl/beat_period_meter.sv
module beat_period_meter #(
    parameter int PER_W   = 10,
    parameter int PER_RST = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refresh_i,
    input  logic             peak_i,
    output logic [PER_W-1:0] period_next_o
);
    localparam logic [PER_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] period;
    } meter_t;

    meter_t st_d, st_q;
    logic [PER_W-1:0] meas;
    logic [PER_W:0]   sum;

    always_comb begin
        st_d = st_q;
        meas = st_q.cnt;
        if (refresh_i && (st_q.cnt != CNT_MAX)) begin
            meas = st_q.cnt + 1'b1;
        end
        sum           = {1'b0, st_q.period} + {1'b0, meas};
        period_next_o = peak_i ? sum[PER_W:1] : st_q.period;
        st_d.period   = period_next_o;
        st_d.cnt      = peak_i ? '0 : meas;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt    <= '0;
            st_q.period <= PER_W'(PER_RST);
        end else begin
            st_q <= st_d;
        end
    end

    AST_COUNT_CLEARS_ON_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        peak_i |=> (st_q.cnt == '0)); // R4

    AST_PERIOD_ONLY_ON_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_i |=> $stable(st_q.period)); // R10

    AST_COUNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!peak_i && st_q.cnt == CNT_MAX) |=> (st_q.cnt == CNT_MAX)); // R4
endmodule

// File: rtl/frame_position.sv
module frame_position #(
    parameter int FRAC_W      = 8,
    parameter int LOOP_FRAMES = 16,
    parameter int POS_W       = 16,
    parameter int STEP_W      = 11,
    parameter int LEAD_LOOPS  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           refresh_i,
    input  logic                           peak_i,
    input  logic [STEP_W-1:0]              step_i,
    output logic [POS_W-1:0]               frame_q_o,
    output logic [POS_W-1:0]               goal_next_o,
    output logic [$clog2(LOOP_FRAMES)-1:0] frame_idx_o
);
    localparam int IDX_W = $clog2(LOOP_FRAMES);
    localparam logic [POS_W-1:0] LOOP_Q   = POS_W'(LOOP_FRAMES << FRAC_W);
    localparam logic [POS_W-1:0] LEAD_MAX = POS_W'((LEAD_LOOPS * LOOP_FRAMES) << FRAC_W);
    localparam logic [POS_W-1:0] ROOM_MAX = LEAD_MAX - LOOP_Q;

    typedef struct packed {
        logic [POS_W-1:0] frame;
        logic [POS_W-1:0] goal;
    } pos_t;

    pos_t st_d, st_q;
    logic [POS_W-1:0] lead;
    logic [POS_W-1:0] step_x;
    logic [POS_W-1:0] advance;

    always_comb begin
        st_d    = st_q;
        lead    = st_q.goal - st_q.frame;
        step_x  = POS_W'(step_i);
        advance = '0;
        if (refresh_i && (lead != '0)) begin
            advance = (step_x > lead) ? lead : step_x;
        end
        st_d.frame  = st_q.frame + advance;
        goal_next_o = st_q.goal;
        if (peak_i && (lead <= ROOM_MAX)) begin
            goal_next_o = st_q.goal + LOOP_Q;
        end
        st_d.goal = goal_next_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.frame <= '0;
            st_q.goal  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_q_o   = st_q.frame;
    assign frame_idx_o = st_q.frame[FRAC_W +: IDX_W];

    AST_FRAME_NOT_PAST_GOAL: assert property (@(posedge clk) disable iff (!rst_n)
        (POS_W'(st_q.goal - st_q.frame) <= LEAD_MAX)); // R3

    AST_FRAME_HOLDS_NO_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_i |=> $stable(st_q.frame)); // R3

    AST_GOAL_ONLY_ON_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_i |=> $stable(st_q.goal)); // R10
endmodule

// File: rtl/step_loop.sv
module step_loop #(
    parameter int FRAC_W   = 8,
    parameter int POS_W    = 16,
    parameter int PER_W    = 10,
    parameter int STEP_W   = 11,
    parameter int STEP_MAX = 1024,
    parameter int STEP_RST = 68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              peak_i,
    input  logic [POS_W-1:0]  frame_i,
    input  logic [POS_W-1:0]  goal_next_i,
    input  logic [PER_W-1:0]  period_next_i,
    output logic [STEP_W-1:0] step_o
);
    localparam int PROD_W = PER_W + STEP_W;
    localparam int ERR_W  = (PROD_W + 2 > POS_W + 1) ? PROD_W + 2 : POS_W + 1;
    localparam logic signed [ERR_W-1:0] STEP_MAX_X = ERR_W'(STEP_MAX);

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } loop_t;

    loop_t st_d, st_q;
    logic [POS_W-1:0]         diff;
    logic [PROD_W-1:0]        prod;
    logic signed [ERR_W-1:0]  diff_x;
    logic signed [ERR_W-1:0]  prod_x;
    logic signed [ERR_W-1:0]  err;
    logic signed [ERR_W-1:0]  adj;
    logic signed [ERR_W-1:0]  cand;
    logic [STEP_W-1:0]        clamped;

    always_comb begin
        st_d   = st_q;
        diff   = frame_i - goal_next_i;
        prod   = {{STEP_W{1'b0}}, period_next_i} * {{PER_W{1'b0}}, st_q.step};
        diff_x = ERR_W'($signed(diff));
        prod_x = ERR_W'(prod);
        err    = diff_x + prod_x;
        adj    = err >>> FRAC_W;
        cand   = ERR_W'(st_q.step) - adj;
        if (cand < 0) begin
            clamped = '0;
        end else if (cand > STEP_MAX_X) begin
            clamped = STEP_W'(STEP_MAX);
        end else begin
            clamped = cand[STEP_W-1:0];
        end
        if (peak_i) begin
            st_d.step = clamped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.step <= STEP_W'(STEP_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o = st_q.step;

    AST_STEP_WITHIN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step <= STEP_W'(STEP_MAX))); // R8

    AST_STEP_ONLY_ON_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_i |=> $stable(st_q.step)); // R10
endmodule

// File: rtl/beat_anim_sequencer.sv
module beat_anim_sequencer
    import beat_anim_pkg::*;
#(
    parameter int FRAC_W       = FRAC_BITS_DEF,
    parameter int LOOP_FRAMES  = LOOP_LEN_DEF,
    parameter int POS_W        = POS_BITS_DEF,
    parameter int PER_W        = PERIOD_BITS_DEF,
    parameter int STEP_MAX_INT = STEP_CAP_DEF,
    parameter int LEAD_LOOPS   = LEAD_LOOPS_DEF,
    parameter int PER_RST      = PERIOD_INIT_DEF
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           refresh_i,
    input  logic                           peak_i,
    output logic [$clog2(LOOP_FRAMES)-1:0] frame_idx_o
);
    localparam int STEP_W   = FRAC_W + $clog2(STEP_MAX_INT + 1);
    localparam int STEP_MAX = STEP_MAX_INT << FRAC_W;
    localparam int STEP_RST = (LOOP_FRAMES << FRAC_W) / PER_RST;

    logic [PER_W-1:0]  period_next;
    logic [POS_W-1:0]  frame_q;
    logic [POS_W-1:0]  goal_next;
    logic [STEP_W-1:0] step;

    beat_period_meter #(
        .PER_W   (PER_W),
        .PER_RST (PER_RST)
    ) u_meter (
        .clk           (clk),
        .rst_n         (rst_n),
        .refresh_i     (refresh_i),
        .peak_i        (peak_i),
        .period_next_o (period_next)
    );

    frame_position #(
        .FRAC_W      (FRAC_W),
        .LOOP_FRAMES (LOOP_FRAMES),
        .POS_W       (POS_W),
        .STEP_W      (STEP_W),
        .LEAD_LOOPS  (LEAD_LOOPS)
    ) u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .refresh_i   (refresh_i),
        .peak_i      (peak_i),
        .step_i      (step),
        .frame_q_o   (frame_q),
        .goal_next_o (goal_next),
        .frame_idx_o (frame_idx_o)
    );

    step_loop #(
        .FRAC_W   (FRAC_W),
        .POS_W    (POS_W),
        .PER_W    (PER_W),
        .STEP_W   (STEP_W),
        .STEP_MAX (STEP_MAX),
        .STEP_RST (STEP_RST)
    ) u_loop (
        .clk           (clk),
        .rst_n         (rst_n),
        .peak_i        (peak_i),
        .frame_i       (frame_q),
        .goal_next_i   (goal_next),
        .period_next_i (period_next),
        .step_o        (step)
    );
endmodule

// File: tb/tb_beat_anim_sequencer.sv
module tb_beat_anim_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       refresh_i = 1'b0;
    logic       peak_i = 1'b0;
    logic [3:0] frame_idx_o;

    int checks = 0;
    int errors = 0;

    // Reference state built from the requirements
    int m_frame, m_goal, m_step, m_period, m_cnt;

    always #4 clk = ~clk;

    beat_anim_sequencer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .refresh_i   (refresh_i),
        .peak_i      (peak_i),
        .frame_idx_o (frame_idx_o)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic model_step(input logic r, input logic p);
        int meas, lead, ngoal, nper, err, st;
        meas = m_cnt + (r ? 1 : 0);
        if (meas > 1023) meas = 1023;
        lead = m_goal - m_frame;
        if (p) begin
            nper  = (m_period + meas) / 2;                         // R5
            ngoal = (lead + 4096 <= 16384) ? m_goal + 4096 : m_goal; // R6
            err   = (m_frame - ngoal) + nper * m_step;             // R7
            st    = m_step - (err >>> 8);
            if (st < 0) st = 0;                                    // R8
            if (st > 1024) st = 1024;
            m_period = nper;
            m_goal   = ngoal;
            m_step   = st;
        end
        if (r && lead > 0) begin
            m_frame = m_frame + ((st_lim(lead)));
        end
        m_cnt = p ? 0 : meas;
    endtask

    function automatic int st_lim(input int lead);
        return (m_step_prev < lead) ? m_step_prev : lead;
    endfunction

    int m_step_prev;

    task automatic tick(input logic r, input logic p);
        @(negedge clk);
        refresh_i = r;
        peak_i    = p;
        m_step_prev = m_step;
        @(posedge clk);
        model_step(r, p);
        #1;
        check("R3 tracking", int'(frame_idx_o), (m_frame >> 8) & 15);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; refresh_i = 1'b0; peak_i = 1'b0;
        m_frame = 0; m_goal = 0; m_step = 68; m_period = 60; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset index", int'(frame_idx_o), 0);
    endtask

    task automatic t_idle_before_peak();
        do_reset();
        repeat (20) tick(1'b1, 1'b0);
        check("R1 no motion before first peak", int'(frame_idx_o), 0);
    endtask

    task automatic t_first_beat();
        do_reset();
        tick(1'b0, 1'b1);                       // step 68 -> 77
        check("R3 peak alone holds position", int'(frame_idx_o), 0);
        repeat (10) tick(1'b1, 1'b0);
        check("R7 step 77 after 10 refreshes", int'(frame_idx_o), 3);
        repeat (10) tick(1'b1, 1'b0);
        check("R10 step unchanged without peak", int'(frame_idx_o), 6);
        repeat (34) tick(1'b1, 1'b0);
        check("R3 stops at goal (16 frames)", int'(frame_idx_o), 0);
        repeat (5) tick(1'b1, 1'b0);
        check("R3 held at goal", int'(frame_idx_o), 0);
    endtask

    task automatic t_coincident(input logic together, input int expected);
        do_reset();
        repeat (45) tick(1'b1, 1'b0);
        if (together) tick(1'b1, 1'b1);         // measured 46 -> step 70
        else          tick(1'b0, 1'b1);         // measured 45 -> step 71
        repeat (40) tick(1'b1, 1'b0);
        check(together ? "R4 strobe with peak counted" : "R5 averaged period",
              int'(frame_idx_o), expected);
    endtask

    task automatic t_long_beat();
        do_reset();
        repeat (1100) tick(1'b1, 1'b0);
        tick(1'b0, 1'b1);                       // saturated 1023 -> step clamps at 0
        repeat (10) tick(1'b1, 1'b0);
        check("R4 saturation / R8 clamp at 0", int'(frame_idx_o), 0);
    endtask

    task automatic t_peak_burst();
        do_reset();
        repeat (30) tick(1'b0, 1'b1);
        check("R3 peaks without refresh hold", int'(frame_idx_o), 0);
        tick(1'b1, 1'b0);
        check("R8 step clamped at 4.0", int'(frame_idx_o), 4);
        repeat (3) tick(1'b1, 1'b0);
        check("R2 index wraps at 16", int'(frame_idx_o), 0);
        tick(1'b1, 1'b0);
        check("R2 index after wrap", int'(frame_idx_o), 4);
        repeat (12) tick(1'b1, 1'b0);
        check("R6 goal capped at 64 frames", int'(frame_idx_o), 0);
        repeat (4) tick(1'b1, 1'b0);
        check("R6 no motion past capped goal", int'(frame_idx_o), 0);
    endtask

    task automatic t_lock();
        do_reset();
        for (int b = 0; b < 30; b++) begin
            repeat (40) tick(1'b1, 1'b0);
            if (b >= 25) begin
                checks++;
                if (frame_idx_o != 4'd0 && frame_idx_o != 4'd15) begin
                    errors++;
                    $display("FAIL R9 lock: actual %0d expected 15 or 0", frame_idx_o);
                end
            end
            tick(1'b0, 1'b1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_step_prev = 68;
        t_idle_before_peak();
        t_first_beat();
        t_coincident(1'b1, 10);
        t_coincident(1'b0, 11);
        t_long_beat();
        t_peak_burst();
        t_lock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule